// File: doc/BRIEF.md
# Four-Mode Eight-Output Addressable Latch

This block stores eight bits, one per output, and writes them one at a time through a three-bit address and a single data input. Two control inputs, an active-low enable and an active-high clear, pick one of four modes: latch (only the addressed bit takes the data value, the rest keep theirs), memory (every bit holds), demultiplexer (the addressed bit takes the data value, every other bit goes low) and clear (every bit goes low).

This version is synchronous and suits FPGA fabric. The mode, address and data are sampled on each rising clock edge. The output register then takes the value that the sampled mode gives. Whatever a writing mode produces becomes the stored state. Going into memory mode after a demultiplexer or clear cycle therefore keeps that cycle's result.

The mode decoder is the block's state selector. Its four named states are MODE_LATCH (enable low, clear low), MODE_HOLD (enable high, clear low), MODE_DEMUX (enable low, clear high) and MODE_CLEAR (enable high, clear high). The mode can change from any state to any other on any clock edge. Each such transition takes effect on the next clock edge.

Top module: `alatch8`

## Requirements
- R1: While reset (rst_n low) is held through a rising clock edge, q is 8'h00 after that edge.
- R2: In MODE_CLEAR (en_n=1, clr=1), q is 8'h00 after the next rising edge, whatever addr and d are.
- R3: In MODE_DEMUX (en_n=0, clr=1), after the next rising edge bit q[addr] equals d and every other bit is 0.
- R4: In MODE_LATCH (en_n=0, clr=0), after the next rising edge bit q[addr] equals d, where addr is an unsigned binary bit index with 0 selecting q[0].
- R5: In MODE_LATCH, every bit other than q[addr] keeps the value it had before the edge.
- R6: In MODE_HOLD (en_n=1, clr=0), q is unchanged across the edge, whatever addr and d are.
- R7: After a MODE_DEMUX or MODE_CLEAR cycle, later MODE_HOLD cycles keep the pattern that cycle produced.
- R8: q changes only at a rising clock edge. Input changes between edges do not show on q until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 3 | Bit index to write |
| d | input | 1 | Data value for the addressed bit |
| en_n | input | 1 | Enable, active low |
| clr | input | 1 | Clear, active high |
| q | output | 8 | Stored bits |

## Verification
A fixed sequence of vectors writes scattered ones, overwrites them and mixes the modes. It separates latch mode, which keeps the earlier ones, from demultiplexer mode, which wipes them. It also shows that memory mode keeps whatever the previous writing mode left. A sweep then drives every address in each of the four modes with alternating data, against a reference model. Preloading q with ones before the demultiplexer pass shows that clearing the unaddressed bits is real and not left over from reset. Directed cases cover a reset in the middle of a run and the one-edge latency of an input change.

// File: rtl/alatch8_pkg.sv
package alatch8_pkg;
    typedef enum logic [1:0] {
        MODE_LATCH = 2'b00,
        MODE_HOLD  = 2'b01,
        MODE_DEMUX = 2'b10,
        MODE_CLEAR = 2'b11
    } alatch_mode_t;
endpackage

// File: rtl/alatch8_mode_dec.sv
module alatch8_mode_dec
    import alatch8_pkg::*;
(
    input  logic         en_n,
    input  logic         clr,
    output alatch_mode_t mode
);
    always_comb begin
        unique case ({clr, en_n})
            2'b00:   mode = MODE_LATCH;
            2'b01:   mode = MODE_HOLD;
            2'b10:   mode = MODE_DEMUX;
            default: mode = MODE_CLEAR;
        endcase
    end
endmodule

// File: rtl/alatch8_sel.sv
module alatch8_sel #(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NBITS-1:0]  sel
);
    for (genvar i = 0; i < NBITS; i++) begin : g_dec
        assign sel[i] = (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/alatch8_cell.sv
module alatch8_cell
    import alatch8_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  alatch_mode_t mode,
    input  logic         sel,
    input  logic         d,
    output logic         q
);
    logic q_next;

    always_comb begin
        unique case (mode)
            MODE_LATCH: q_next = sel ? d : q;
            MODE_HOLD:  q_next = q;
            MODE_DEMUX: q_next = sel & d;
            MODE_CLEAR: q_next = 1'b0;
            default:    q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_next;
    end
endmodule

// File: rtl/alatch8.sv
module alatch8
    import alatch8_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              d,
    input  logic              en_n,
    input  logic              clr,
    output logic [NBITS-1:0]  q
);
    alatch_mode_t     mode;
    logic [NBITS-1:0] sel;

    alatch8_mode_dec u_dec (
        .en_n (en_n),
        .clr  (clr),
        .mode (mode)
    );

    alatch8_sel #(.ADDR_W(ADDR_W)) u_sel (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        alatch8_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .sel   (sel[i]),
            .d     (d),
            .q     (q[i])
        );
    end
endmodule

// File: rtl/alatch8_chk.sv
module alatch8_chk #(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              d,
    input logic              en_n,
    input logic              clr,
    input logic [NBITS-1:0]  q
);
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n && clr) |=> (q == '0));

    a_r3_demux_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && clr) |=> (q == ($past(d) ? (NBITS'(1) << $past(addr)) : '0)));

    a_r4_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !clr) |=> (q[$past(addr)] == $past(d)));

    a_r5_latch_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !clr) |=>
        ((q & ~(NBITS'(1) << $past(addr))) == ($past(q) & ~(NBITS'(1) << $past(addr)))));

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n && !clr) |=> $stable(q));
endmodule

bind alatch8 alatch8_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .d     (d),
    .en_n  (en_n),
    .clr   (clr),
    .q     (q)
);

// File: tb/sim_alatch8.sv
module sim_alatch8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       d = 1'b0;
    logic       en_n = 1'b1;
    logic       clr = 1'b0;
    logic [7:0] q;

    int checks = 0;
    int errors = 0;
    logic [7:0] model = '0;

    always #10 clk = ~clk;

    alatch8 u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .d(d),
                .en_n(en_n), .clr(clr), .q(q));

    // {en_n, clr, addr[2:0], d, expected q[7:0]}
    localparam logic [13:0] VEC [12] = '{
        {1'b0, 1'b0, 3'd3, 1'b1, 8'h08},
        {1'b0, 1'b0, 3'd5, 1'b1, 8'h28},
        {1'b0, 1'b0, 3'd0, 1'b1, 8'h29},
        {1'b1, 1'b0, 3'd7, 1'b1, 8'h29},
        {1'b0, 1'b0, 3'd3, 1'b0, 8'h21},
        {1'b0, 1'b1, 3'd6, 1'b1, 8'h40},
        {1'b1, 1'b0, 3'd0, 1'b0, 8'h40},
        {1'b0, 1'b0, 3'd1, 1'b1, 8'h42},
        {1'b1, 1'b1, 3'd2, 1'b1, 8'h00},
        {1'b1, 1'b0, 3'd4, 1'b1, 8'h00},
        {1'b0, 1'b1, 3'd2, 1'b0, 8'h00},
        {1'b0, 1'b0, 3'd7, 1'b1, 8'h80}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: q=%h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic e, input logic c, input logic [2:0] a, input logic dv);
        @(negedge clk);
        en_n = e; clr = c; addr = a; d = dv;
        @(posedge clk);
        #5;
    endtask

    function automatic logic [7:0] ref_next(input logic [7:0] cur, input logic e,
                                            input logic c, input logic [2:0] a,
                                            input logic dv);
        logic [7:0] n = cur;
        case ({c, e})
            2'b00: n[a] = dv;
            2'b01: n = cur;
            2'b10: begin n = '0; n[a] = dv; end
            default: n = '0;
        endcase
        return n;
    endfunction

    function automatic string req_of(input int m);
        case (m)
            0: return "R4/R5";
            1: return "R6";
            2: return "R3";
            default: return "R2";
        endcase
    endfunction

    initial begin : watchdog
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #5;
        check("R1 reset", q, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // vector table: R4 R5 R6 R3 R2 R7
        foreach (VEC[i]) begin
            step(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8]);
            check($sformatf("R4/R5/R6/R3/R2/R7 vec%0d", i), q, VEC[i][7:0]);
        end
        model = VEC[11][7:0];

        // every address in every mode against the reference model
        for (int m = 0; m < 4; m++) begin
            if (m == 2) begin
                for (int k = 0; k < 8; k++) begin
                    step(1'b0, 1'b0, 3'(k), 1'b1);
                    model = ref_next(model, 1'b0, 1'b0, 3'(k), 1'b1);
                end
                check("R4 preload ones", q, 8'hFF);
            end
            for (int a = 0; a < 8; a++) begin
                logic e = m[0];
                logic c = m[1];
                logic dv = (a % 2 == 0);
                step(e, c, 3'(a), dv);
                model = ref_next(model, e, c, 3'(a), dv);
                check(req_of(m), q, model);
            end
        end

        // R7: demux result held by memory mode
        step(1'b0, 1'b1, 3'd5, 1'b1);
        step(1'b1, 1'b0, 3'd1, 1'b1);
        step(1'b1, 1'b0, 3'd6, 1'b0);
        check("R7 hold after demux", q, 8'h20);

        // R8: input change between edges does not show before the edge
        @(negedge clk);
        en_n = 1'b0; clr = 1'b0; addr = 3'd0; d = 1'b1;
        #3;
        check("R8 no change before edge", q, 8'h20);
        @(posedge clk);
        #5;
        check("R8 update at edge", q, 8'h21);

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0; en_n = 1'b0; clr = 1'b0; addr = 3'd2; d = 1'b1;
        @(posedge clk);
        #5;
        check("R1 reset mid-run", q, 8'h00);
        @(negedge clk);
        rst_n = 1'b1; en_n = 1'b1;
        @(posedge clk);
        #5;
        check("R6 hold after reset", q, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule